// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block sequences one 16-bit successive-approximation conversion at a time. After reset, and after every conversion, it runs an acquisition interval of a fixed number of clocks while the sampler tracks the input. It then waits for a start request. When a start is accepted it raises `busy`, which also tells the sampler to hold. It then walks a trial word from bit 15 down to bit 0 on `dac_word`. For each bit it reads a single comparator bit that reports whether the trial is not above the held sample. When the last bit has been decided, the finished word goes straight into `result` and `busy` drops. The falling edge of `busy` is therefore the data-ready strobe, and the word always belongs to the sample just taken.

Two select pins pick one of three throughput modes, and the mode is captured when a conversion starts. In fast mode each bit decision takes fewer clocks. Normal and low-power modes use the longer bit time. In low-power mode a start request that is still held low when acquisition ends starts the next conversion on its own, with no new edge. A power-down request stops new conversions but lets a running one finish. The asynchronous reset aborts any conversion in progress.

Top module: `sar_seq_ctrl`

## Requirements
- R1: A falling edge on `start_n` starts a conversion when acquisition is complete and `pwr_down` is low. `busy` is high from the next clock edge.
- R2: `busy` stays high for exactly 16*FAST_BIT_CLKS clocks in fast mode (`sel_fast`=1, `sel_lowpwr`=0). In every other select combination it stays high for exactly 16*NORM_BIT_CLKS clocks; both selects high counts as normal mode.
- R3: While `rst_n` is low, `busy`, `dac_word` and `result` are 0 at once, and any conversion in progress is abandoned.
- R4: `result` changes only in the clock where `busy` falls, and it then holds the value found for the sample of that same conversion (no pipeline delay).
- R5: The first trial word of a conversion is 16'h8000. Bits are tried from bit 15 down to bit 0. A trial bit is kept when `cmp_keep` is 1 at the end of that bit's time, and cleared when it is 0. `dac_word` is 0 while `busy` is low.
- R6: After reset and after each conversion, acquisition lasts ACQ_CLKS clocks. A start is accepted only after that, so `busy` is low for at least ACQ_CLKS+1 clocks between conversions.
- R7: In low-power mode (`sel_lowpwr`=1, `sel_fast`=0), if `start_n` is still low when acquisition ends, the next conversion starts without a new edge. `busy` is then low for exactly ACQ_CLKS+1 clocks.
- R8: In normal and fast mode, a `start_n` held low with no new falling edge starts nothing.
- R9: A falling edge of `start_n` while `busy` is high is ignored and does not start a later conversion.
- R10: While `pwr_down` is high no conversion starts. A conversion already running when `pwr_down` rises still completes with a correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts a conversion |
| start_n | input | 1 | Active-low conversion start strobe |
| pwr_down | input | 1 | Blocks new conversions when high |
| sel_fast | input | 1 | Fast mode select (when `sel_lowpwr` is low) |
| sel_lowpwr | input | 1 | Low-power mode select (when `sel_fast` is low) |
| cmp_keep | input | 1 | Comparator: 1 when the trial word is not above the sample |
| busy | output | 1 | Conversion in progress; sampler in hold |
| dac_word | output | 16 | Trial word for the capacitor DAC |
| result | output | 16 | Last completed conversion word |

## Verification
The checker assumes that `sel_fast` and `sel_lowpwr` do not change while `busy` is high. It relies on this because it captures the mode in the last cycle before `busy` rises and uses that mode to predict the conversion length. The bench changes the select pins only between conversions, while `busy` is low. It models the comparator from the current `dac_word` against a chosen sample value. A correct sequencer therefore returns that sample exactly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_ACQ   = 2'd0,
    ST_READY = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_t;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_FAST   = 2'd1,
    MD_LOWPWR = 2'd2
  } conv_mode_t;
endpackage

// File: rtl/sar_mode_dec.sv
module sar_mode_dec
  import sar_seq_pkg::*;
(
  input  logic       sel_fast,
  input  logic       sel_lowpwr,
  output conv_mode_t mode
);
  always_comb begin
    if (sel_fast && !sel_lowpwr)      mode = MD_FAST;
    else if (sel_lowpwr && !sel_fast) mode = MD_LOWPWR;
    else                              mode = MD_NORMAL;
  end
endmodule

// File: rtl/sar_start_det.sv
module sar_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= start_n;
  end

  assign fall = prev_q & ~start_n;
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         cmp_keep,
  output logic [W-1:0] trial_word,
  output logic [W-1:0] final_word
);
  localparam logic [W-1:0] MSB_MASK = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] keep_q, keep_d;
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    keep_d = keep_q;
    mask_d = mask_q;
    if (load) begin
      keep_d = '0;
      mask_d = MSB_MASK;
    end else if (step) begin
      if (cmp_keep) keep_d = keep_q | mask_q;
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= '0;
      mask_q <= '0;
    end else if (load || step) begin
      keep_q <= keep_d;
      mask_q <= mask_d;
    end
  end

  assign trial_word = keep_q | mask_q;
  assign final_word = keep_q | (cmp_keep ? mask_q : '0);
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int W             = 16,
  parameter int ACQ_CLKS      = 4,
  parameter int NORM_BIT_CLKS = 3,
  parameter int FAST_BIT_CLKS = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic         pwr_down,
  input  logic         sel_fast,
  input  logic         sel_lowpwr,
  input  logic         cmp_keep,
  output logic         busy,
  output logic [W-1:0] dac_word,
  output logic [W-1:0] result
);
  localparam int AW = $clog2(ACQ_CLKS + 1);
  localparam int TW = $clog2(NORM_BIT_CLKS + 1);
  localparam int BW = $clog2(W);
  localparam logic [AW-1:0] ACQ_LAST  = AW'(ACQ_CLKS - 1);
  localparam logic [TW-1:0] NORM_LAST = TW'(NORM_BIT_CLKS - 1);
  localparam logic [TW-1:0] FAST_LAST = TW'(FAST_BIT_CLKS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(W - 1);

  seq_state_t   state_q, state_d;
  conv_mode_t   mode_now, mode_q, mode_d;
  logic [AW-1:0] acq_q, acq_d;
  logic [TW-1:0] tick_q, tick_d, tick_last_val;
  logic [BW-1:0] bit_q, bit_d;
  logic [W-1:0]  result_d;
  logic [W-1:0]  trial_word, final_word;
  logic          start_fall, trigger, load, step, done;

  sar_mode_dec u_mode (
    .sel_fast   (sel_fast),
    .sel_lowpwr (sel_lowpwr),
    .mode       (mode_now)
  );

  sar_start_det u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_n (start_n),
    .fall    (start_fall)
  );

  sar_approx_reg #(.W(W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .step       (step),
    .cmp_keep   (cmp_keep),
    .trial_word (trial_word),
    .final_word (final_word)
  );

  assign trigger       = start_fall | ((mode_now == MD_LOWPWR) & ~start_n);
  assign tick_last_val = (mode_q == MD_FAST) ? FAST_LAST : NORM_LAST;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    acq_d    = acq_q;
    tick_d   = tick_q;
    bit_d    = bit_q;
    result_d = result;
    load     = 1'b0;
    step     = 1'b0;
    done     = 1'b0;
    unique case (state_q)
      ST_ACQ: begin
        if (acq_q == ACQ_LAST) begin
          state_d = ST_READY;
          acq_d   = '0;
        end else begin
          acq_d = acq_q + 1'b1;
        end
      end
      ST_READY: begin
        if (trigger && !pwr_down) begin
          state_d = ST_CONV;
          mode_d  = mode_now;
          tick_d  = '0;
          bit_d   = '0;
          load    = 1'b1;
        end
      end
      ST_CONV: begin
        if (tick_q == tick_last_val) begin
          step   = 1'b1;
          tick_d = '0;
          if (bit_q == BIT_LAST) begin
            done     = 1'b1;
            state_d  = ST_ACQ;
            acq_d    = '0;
            result_d = final_word;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      default: state_d = ST_ACQ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACQ;
      mode_q  <= MD_NORMAL;
      acq_q   <= '0;
      tick_q  <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      acq_q   <= acq_d;
      tick_q  <= tick_d;
      bit_q   <= bit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result <= '0;
    else if (done) result <= result_d;
  end

  assign busy     = (state_q == ST_CONV);
  assign dac_word = busy ? trial_word : '0;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int W             = 16,
  parameter int NORM_BIT_CLKS = 3,
  parameter int FAST_BIT_CLKS = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_n,
  input logic         pwr_down,
  input logic         sel_fast,
  input logic         sel_lowpwr,
  input logic         busy,
  input logic [W-1:0] dac_word,
  input logic [W-1:0] result
);
  localparam int CW = $clog2(W * NORM_BIT_CLKS + 2);
  localparam logic [CW-1:0] LEN_FAST = CW'(W * FAST_BIT_CLKS);
  localparam logic [CW-1:0] LEN_NORM = CW'(W * NORM_BIT_CLKS);
  localparam logic [W-1:0]  FIRST_TRIAL = {1'b1, {(W-1){1'b0}}};

  logic [CW-1:0] busy_cnt;
  logic          fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      fast_q   <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt + 1'b1;
      else      busy_cnt <= '0;
      if (!busy) fast_q <= sel_fast & ~sel_lowpwr;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == (fast_q ? LEN_FAST : LEN_NORM))); // R2

  AST_START_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!start_n)); // R1

  AST_NO_START_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!pwr_down)); // R10

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(result)); // R4

  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dac_word == FIRST_TRIAL)); // R5

  AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dac_word == '0)); // R5
endmodule

bind sar_seq_ctrl sar_seq_chk #(
  .W             (W),
  .NORM_BIT_CLKS (NORM_BIT_CLKS),
  .FAST_BIT_CLKS (FAST_BIT_CLKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_n    (start_n),
  .pwr_down   (pwr_down),
  .sel_fast   (sel_fast),
  .sel_lowpwr (sel_lowpwr),
  .busy       (busy),
  .dac_word   (dac_word),
  .result     (result)
);

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int ACQ = 4;
  localparam int NB  = 3;
  localparam int FB  = 1;

  logic clk, rst_n, start_n, pwr_down, sel_fast, sel_lowpwr, cmp_keep, busy;
  logic [W-1:0] dac_word, result, sample_val;
  int n_chk, n_fail;

  sar_seq_ctrl #(.W(W), .ACQ_CLKS(ACQ), .NORM_BIT_CLKS(NB), .FAST_BIT_CLKS(FB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .pwr_down(pwr_down),
    .sel_fast(sel_fast), .sel_lowpwr(sel_lowpwr), .cmp_keep(cmp_keep),
    .busy(busy), .dac_word(dac_word), .result(result)
  );

  assign cmp_keep = (dac_word <= sample_val);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic wait_ready();
    repeat (ACQ + 2) @(negedge clk);
  endtask

  // Runs one conversion from an edge; returns after busy falls.
  task automatic run_conv(input logic [W-1:0] s, input bit fast, input bit lowp, input bit hold_low);
    int cnt;
    int exp_len;
    sample_val = s;
    sel_fast   = fast;
    sel_lowpwr = lowp;
    exp_len    = fast && !lowp ? W*FB : W*NB;
    start_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R1 busy after edge", int'(busy), 1);
    check(dac_word == 16'h8000, "R5 first trial", int'(dac_word), 16'h8000);
    cnt = 0;
    while (busy && cnt < 200) begin
      cnt++;
      if (!hold_low) start_n = 1'b1;
      @(negedge clk);
    end
    check(cnt == exp_len, "R2 busy length", cnt, exp_len);
    check(result == s, "R4 result value", int'(result), int'(s));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_n = 1'b1; pwr_down = 1'b0;
    sel_fast = 1'b0; sel_lowpwr = 1'b0; sample_val = '0;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R3 reset busy", int'(busy), 0);
    check(result == '0, "R3 reset result", int'(result), 0);
    check(dac_word == '0, "R5 idle dac", int'(dac_word), 0);
    rst_n = 1'b1;
    wait_ready();
  endtask

  task automatic t_modes();
    run_conv(16'hA5C3, 1'b0, 1'b0, 1'b0); wait_ready();  // R4 normal
    run_conv(16'h0000, 1'b1, 1'b0, 1'b0); wait_ready();  // R2 fast, all bits dropped
    run_conv(16'hFFFF, 1'b0, 1'b1, 1'b0); wait_ready();  // R5 all bits kept
    run_conv(16'h8000, 1'b1, 1'b1, 1'b0); wait_ready();  // R2 both selects: normal
    run_conv(16'h7FFF, 1'b1, 1'b0, 1'b0); wait_ready();
  endtask

  task automatic t_level_lowpwr();
    int gap;
    run_conv(16'h1234, 1'b0, 1'b1, 1'b1);
    gap = 0;
    while (!busy && gap < 50) begin gap++; @(negedge clk); end
    check(gap == ACQ + 1, "R7 level start gap", gap, ACQ + 1);
    check(gap >= ACQ + 1, "R6 acquisition length", gap, ACQ + 1);
    sample_val = 16'h4321;
    start_n = 1'b1;
    while (busy) @(negedge clk);
    check(result == 16'h4321, "R7 second result", int'(result), 16'h4321);
    wait_ready();
  endtask

  task automatic t_level_normal();
    run_conv(16'h0F0F, 1'b0, 1'b0, 1'b1);
    repeat (ACQ + 10) @(negedge clk);
    check(busy == 1'b0, "R8 held low no start", int'(busy), 0);
    check(result == 16'h0F0F, "R8 result kept", int'(result), 16'h0F0F);
    start_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_edge_in_busy();
    sample_val = 16'h3C3C; sel_fast = 1'b0; sel_lowpwr = 1'b0;
    start_n = 1'b0; @(negedge clk);
    start_n = 1'b1; repeat (5) @(negedge clk);
    start_n = 1'b0; @(negedge clk);
    start_n = 1'b1;
    while (busy) @(negedge clk);
    repeat (ACQ + 6) @(negedge clk);
    check(busy == 1'b0, "R9 edge in busy ignored", int'(busy), 0);
    check(result == 16'h3C3C, "R9 result", int'(result), 16'h3C3C);
  endtask

  task automatic t_powerdown();
    sample_val = 16'hBEEF; sel_fast = 1'b1; sel_lowpwr = 1'b0;
    start_n = 1'b0; @(negedge clk);
    start_n = 1'b1; pwr_down = 1'b1;
    while (busy) @(negedge clk);
    check(result == 16'hBEEF, "R10 running conv completes", int'(result), 16'hBEEF);
    wait_ready();
    start_n = 1'b0; @(negedge clk);
    start_n = 1'b1; repeat (3) @(negedge clk);
    check(busy == 1'b0, "R10 start blocked", int'(busy), 0);
    pwr_down = 1'b0;
    run_conv(16'h0001, 1'b1, 1'b0, 1'b0);
    wait_ready();
  endtask

  task automatic t_abort();
    sample_val = 16'hFFFF; sel_fast = 1'b0; sel_lowpwr = 1'b0;
    start_n = 1'b0; @(negedge clk);
    start_n = 1'b1; repeat (10) @(negedge clk);
    rst_n = 1'b0; #1;
    check(busy == 1'b0, "R3 abort busy", int'(busy), 0);
    check(result == '0, "R3 abort result", int'(result), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_ready();
    run_conv(16'h5A5A, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    t_reset();
    t_modes();
    t_level_lowpwr();
    t_level_normal();
    t_edge_in_busy();
    t_powerdown();
    t_abort();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule